// File: doc/BRIEF.md
# Slow-Clock Frequency Meter

This block measures how fast a nominal 32768 Hz slow clock really runs by counting cycles of a fast reference clock, nominally 24 MHz. Software sets a gate length in whole slow-clock seconds and starts a run. The block then opens a gate for exactly (length+1) seconds of the slow clock and counts the reference cycles for which the gate is open. An ideal slow clock gives 24,000,000 × (length+1).

The gate is built in the slow domain. It crosses into the reference domain through a two-flop synchronizer. The run request crosses the other way as a toggle, also through a two-flop synchronizer. When the gate closes, the count is latched and exposed as four byte-wide registers, least significant byte first. Software polls the done bit and then reads the bytes. The register port works in the reference clock domain, with writes taken on a clock edge and reads returned combinationally.

Top module: `clk_meas_counter`

## Requirements
- R1: After reset, every register reads zero: the control register (0x80), the status register (0x84), the length register (0x88) and all four result bytes.
- R2: Bit 0 of the control register at 0x80 is the measurement enable and reads back as written. The length register at 0x88 holds LEN_W bits and reads back as written.
- R3: Writing 1 to bit 0 of the status register (0x84) while enabled and idle starts a run. The busy flag (status bit 1) reads 1 from the next cycle on, and status bit 0 always reads 0.
- R4: A start written while the enable bit is 0 is ignored. Busy stays 0 and the done flag and the result keep their values.
- R5: A run gates counting for exactly (length+1)×SLOW_HZ slow-clock cycles. The result is the number of reference cycles for which the synchronized gate was high. When the reference period divides the slow period by an integer ratio K with a fixed phase, the result is (length+1)×SLOW_HZ×K.
- R6: The result reads in bits [7:0] of 0x8C, 0x90, 0x94 and 0x98, least significant byte first.
- R7: When the gate closes, the done flag (status bit 2) sets and busy clears in the same cycle. Done stays set until the next accepted start.
- R8: An accepted start clears the done flag and the counter in the next cycle.
- R9: A start written while a run is busy is ignored. The run continues and its result is unaffected.
- R10: The length is captured when a run starts. Writing the length register during a run changes the register but not the window of that run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk_i | input | 1 | Reference clock; also clocks the register port |
| slow_clk_i | input | 1 | Slow clock under measurement |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for reg_addr_i |

## Verification
The bench builds the block with SLOW_HZ = 4, so one gate "second" is only four slow cycles. This puts the full length range, including the maximum of 255, within a short run. The slow clock period is eight reference periods and keeps a fixed phase offset. Both synchronizers therefore delay the gate edges by the same amount, and every expected count is exactly 32×(length+1). Start requests are also issued while idle, busy and disabled, and the length is rewritten in mid-run, to cover the ignore and capture rules.

// File: rtl/clk_meas_pkg.sv
package clk_meas_pkg;
  localparam int unsigned OFS_CTRL = 'h80;
  localparam int unsigned OFS_STAT = 'h84;
  localparam int unsigned OFS_LEN  = 'h88;
  localparam int unsigned OFS_RES0 = 'h8C;
  localparam int unsigned RES_STEP = 4;

  localparam int unsigned BIT_EN    = 0;
  localparam int unsigned BIT_START = 0;
  localparam int unsigned BIT_BUSY  = 1;
  localparam int unsigned BIT_DONE  = 2;
endpackage

// File: rtl/clk_meas_sync.sv
module clk_meas_sync #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/clk_meas_window.sv
// Slow-domain gate generator: (len+1) * SLOW_HZ slow cycles per run.
module clk_meas_window #(
  parameter int unsigned SLOW_HZ = 32768,
  parameter int unsigned LEN_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             gate_o
);
  localparam int unsigned TICK_W = (SLOW_HZ > 1) ? $clog2(SLOW_HZ) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(SLOW_HZ - 1);

  logic              req_q;
  logic              gate_q;
  logic [TICK_W-1:0] tick_q;
  logic [LEN_W-1:0]  sec_q;
  logic              new_run;

  assign new_run = req_i ^ req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      gate_q <= 1'b0;
      tick_q <= '0;
      sec_q  <= '0;
    end else begin
      req_q <= req_i;
      if (new_run) begin
        gate_q <= 1'b1;
        tick_q <= TICK_LAST;
        sec_q  <= len_i;   // stable: captured in ref domain before toggle
      end else if (gate_q) begin
        if (tick_q == '0) begin
          if (sec_q == '0) begin
            gate_q <= 1'b0;
          end else begin
            sec_q  <= sec_q - 1'b1;
            tick_q <= TICK_LAST;
          end
        end else begin
          tick_q <= tick_q - 1'b1;
        end
      end
    end
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/clk_meas_refcnt.sv
// Reference-domain counter, run control and result latch.
module clk_meas_refcnt #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             gate_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] result_o,
  output logic             req_o,
  output logic [LEN_W-1:0] len_run_o
);
  logic             busy_q, done_q, req_q, gate_q;
  logic [CNT_W-1:0] cnt_q, res_q;
  logic [LEN_W-1:0] len_q;
  logic             gate_fall;

  assign gate_fall = gate_q & ~gate_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      req_q  <= 1'b0;
      gate_q <= 1'b0;
      cnt_q  <= '0;
      res_q  <= '0;
      len_q  <= '0;
    end else begin
      gate_q <= gate_i;
      if (start_i) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
        cnt_q  <= '0;
        len_q  <= len_i;
        req_q  <= ~req_q;
      end else begin
        if (gate_i && (cnt_q != '1)) cnt_q <= cnt_q + 1'b1;   // saturate
        if (busy_q && gate_fall) begin
          res_q  <= cnt_q;
          done_q <= 1'b1;
          busy_q <= 1'b0;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign result_o  = res_q;
  assign req_o     = req_q;
  assign len_run_o = len_q;
endmodule

// File: rtl/clk_meas_regs.sv
module clk_meas_regs
  import clk_meas_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned LEN_W     = 8,
  parameter int unsigned RES_BYTES = 4,
  localparam int unsigned CNT_W    = 8 * RES_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [CNT_W-1:0]  result_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              enable_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              start_o
);
  logic             en_q;
  logic [LEN_W-1:0] len_q;
  logic             hit_ctrl, hit_stat, hit_len;

  assign hit_ctrl = (addr_i == ADDR_W'(OFS_CTRL));
  assign hit_stat = (addr_i == ADDR_W'(OFS_STAT));
  assign hit_len  = (addr_i == ADDR_W'(OFS_LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      len_q <= '0;
    end else if (we_i) begin
      if (hit_ctrl) en_q  <= wdata_i[BIT_EN];
      if (hit_len)  len_q <= wdata_i[LEN_W-1:0];
    end
  end

  assign start_o  = we_i & hit_stat & wdata_i[BIT_START] & en_q & ~busy_i;
  assign enable_o = en_q;
  assign len_o    = len_q;

  always_comb begin
    rdata_o = '0;
    if (hit_ctrl) rdata_o[BIT_EN] = en_q;
    if (hit_stat) begin
      rdata_o[BIT_BUSY] = busy_i;
      rdata_o[BIT_DONE] = done_i;
    end
    if (hit_len) rdata_o[LEN_W-1:0] = len_q;
    for (int i = 0; i < RES_BYTES; i++) begin
      if (addr_i == ADDR_W'(OFS_RES0 + RES_STEP * i))
        rdata_o[7:0] = result_i[8*i +: 8];
    end
  end
endmodule

// File: rtl/clk_meas_counter.sv
module clk_meas_counter #(
  parameter int unsigned SLOW_HZ   = 32768,
  parameter int unsigned LEN_W     = 8,
  parameter int unsigned RES_BYTES = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned CNT_W    = 8 * RES_BYTES
) (
  input  logic              ref_clk_i,
  input  logic              slow_clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o
);
  logic             enable, start_pulse, busy, done;
  logic [LEN_W-1:0] len_reg, len_run;
  logic [CNT_W-1:0] result;
  logic             req_ref, req_slow, gate_slow, gate_ref;

  clk_meas_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .RES_BYTES(RES_BYTES)
  ) u_regs (
    .clk_i(ref_clk_i), .rst_ni(rst_ni),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .busy_i(busy), .done_i(done), .result_i(result),
    .rdata_o(reg_rdata_o), .enable_o(enable), .len_o(len_reg),
    .start_o(start_pulse)
  );

  clk_meas_refcnt #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_refcnt (
    .clk_i(ref_clk_i), .rst_ni(rst_ni),
    .start_i(start_pulse), .len_i(len_reg), .gate_i(gate_ref),
    .busy_o(busy), .done_o(done), .result_o(result),
    .req_o(req_ref), .len_run_o(len_run)
  );

  clk_meas_sync #(.WIDTH(1)) u_sync_req (
    .clk_i(slow_clk_i), .rst_ni(rst_ni), .d_i(req_ref), .q_o(req_slow)
  );

  clk_meas_window #(.SLOW_HZ(SLOW_HZ), .LEN_W(LEN_W)) u_window (
    .clk_i(slow_clk_i), .rst_ni(rst_ni),
    .req_i(req_slow), .len_i(len_run), .gate_o(gate_slow)
  );

  clk_meas_sync #(.WIDTH(1)) u_sync_gate (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .d_i(gate_slow), .q_o(gate_ref)
  );

  logic unused_enable;
  assign unused_enable = enable;
endmodule

// File: rtl/clk_meas_counter_chk.sv
module clk_meas_counter_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_i,
  input logic             done_i,
  input logic             gate_i,
  input logic [CNT_W-1:0] result_i
);
  a_r3_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_i);
  a_r8_start_clears_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_i);
  a_r7_busy_done_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_i && done_i));
  a_r7_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !start_i) |=> done_i);
  a_r9_busy_while_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && gate_i) |=> busy_i);
  a_r5_result_only_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_i) |-> $rose(done_i));
endmodule

bind clk_meas_counter clk_meas_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(ref_clk_i), .rst_ni(rst_ni), .start_i(start_pulse),
  .busy_i(busy), .done_i(done), .gate_i(gate_ref), .result_i(result)
);

// File: tb/clk_meas_counter_test.sv
module clk_meas_counter_test;
  localparam int REF_PERIOD = 10;
  localparam int SLOW_RATIO = 8;
  localparam int T_SLOW_HZ  = 4;
  localparam int NVEC       = 4;
  localparam int unsigned VEC_LEN [NVEC] = '{0, 1, 3, 9};
  localparam int unsigned VEC_EXP [NVEC] = '{32, 64, 128, 320};

  logic        ref_clk = 1'b0, slow_clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  int          n_run = 0, n_fail = 0;

  clk_meas_counter #(.SLOW_HZ(T_SLOW_HZ)) uut (
    .ref_clk_i(ref_clk), .slow_clk_i(slow_clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  always #(REF_PERIOD/2) ref_clk = ~ref_clk;
  initial begin
    #3;
    forever #(REF_PERIOD*SLOW_RATIO/2) slow_clk = ~slow_clk;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge ref_clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge ref_clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge ref_clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_done(output logic ok);
    logic [31:0] s;
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      rd(8'h84, s);
      if (s[2]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic rd_result(output logic [31:0] r);
    logic [31:0] b;
    for (int i = 0; i < 4; i++) begin
      rd(8'(8'h8C + 4*i), b);
      r[8*i +: 8] = b[7:0];
    end
  endtask

  initial begin
    repeat (150000) @(posedge ref_clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, r;
    logic ok;
    repeat (3) @(negedge ref_clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(8'h80, v); check("R1 ctrl", v, 0);
    rd(8'h84, v); check("R1 status", v, 0);
    rd(8'h88, v); check("R1 length", v, 0);
    rd_result(r); check("R1 result", r, 0);

    // R2 readback
    wr(8'h80, 32'h1); rd(8'h80, v); check("R2 enable", v, 1);
    wr(8'h88, 32'hA5); rd(8'h88, v); check("R2 length", v, 32'hA5);

    // R5/R6/R7 table of runs
    for (int k = 0; k < NVEC; k++) begin
      wr(8'h88, VEC_LEN[k]);
      wr(8'h84, 32'h1);
      rd(8'h84, v); check("R3 busy set, start reads 0", v, 32'h2);
      wait_done(ok); check("R7 done reached", 32'(ok), 1);
      rd(8'h84, v); check("R7 done set busy clear", v, 32'h4);
      rd_result(r); check("R5 R6 result", r, VEC_EXP[k]);
    end

    // R7 done stays set
    repeat (100) @(negedge ref_clk);
    rd(8'h84, v); check("R7 done sticky", v, 32'h4);

    // R8 start clears done
    wr(8'h88, 32'd255);
    wr(8'h84, 32'h1);
    rd(8'h84, v); check("R8 done cleared on start", v, 32'h2);
    wait_done(ok); check("R7 done reached max", 32'(ok), 1);
    rd_result(r); check("R5 max length", r, 32'd8192);

    // R9 restart ignored, R10 length captured
    wr(8'h88, 32'd1);
    wr(8'h84, 32'h1);
    wr(8'h88, 32'd5);
    wr(8'h84, 32'h1);
    rd(8'h84, v); check("R9 still busy", v, 32'h2);
    wait_done(ok); check("R9 done reached", 32'(ok), 1);
    rd_result(r); check("R9 R10 result of first run", r, 32'd64);
    rd(8'h88, v); check("R10 length rewritten", v, 32'd5);
    repeat (200) @(negedge ref_clk);
    rd(8'h84, v); check("R9 no second run", v, 32'h4);

    // R4 start ignored when disabled
    wr(8'h80, 32'h0);
    wr(8'h84, 32'h1);
    rd(8'h84, v); check("R4 no start when disabled", v, 32'h4);
    repeat (300) @(negedge ref_clk);
    rd_result(r); check("R4 result kept", r, 32'd64);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule